// File: doc/BRIEF.md
# Track buffer seek handshake controller

This block sits between the command logic of an emulated cartridge disk drive and a host that keeps the disk images. The two sides share one track buffer. The buffer holds every surface of the current cylinder for both the fixed and the removable platter. A single 32-bit status word, placed in the unused tail of the first 512-byte block, carries the handshake between them.

When the drive side asks for a new cylinder, the block records it in the status word and reports the seek as busy. If the drive wrote any sector since the current track was loaded, the block also raises a dirty flag, so the host knows to copy the old track back to its image first. The host loads the new track and then writes the loaded track number back. When that number matches the request, the seek completes.

The host also controls whether the unit is online. An offline unit reports not-ready to the drive side and accepts no seeks. Cylinders run from 0 to 203, and a request beyond that range is flagged as a seek error.

Top module: `tbsk_top`

## Requirements
- R1: After reset the status word reads 0 (offline, clean, requested and loaded track 0), and `ready`, `seek_busy`, `seek_done` and `seek_err` are all low.
- R2: A host write to word address 127 (byte offset 508 of block 0) updates the online bit (bit 31) and the loaded track (bits 7:0), and `ready` follows the online bit from the next cycle. A host write to any other address changes nothing.
- R3: When the unit is online and idle, a seek request for cylinder 0..203 raises `seek_busy` in the next cycle and places the cylinder in status bits 23:16. The requested cylinder never exceeds 203.
- R4: When the unit is online and idle, a seek request above 203 pulses `seek_err` high for exactly one cycle (the next cycle). It leaves `seek_busy` and status bits 23:16 unchanged.
- R5: When a seek is accepted, status bit 30 (dirty) is set if at least one drive-side buffer write (`drv_we`) occurred since the current track was loaded, and cleared otherwise.
- R6: While a seek is busy, a host status write with online set and a loaded track equal to the requested cylinder ends the seek. In the next cycle `seek_busy` is low, `seek_done` is high for exactly one cycle, bits 7:0 equal the request and the dirty bit is 0.
- R7: While a seek is busy, a host status write whose loaded track differs from the request updates bits 7:0. It keeps `seek_busy` high and leaves the dirty bit unchanged.
- R8: A host status write with the online bit clear drops `ready` and `seek_busy` in the next cycle without a `seek_done` pulse. Seek requests while offline are ignored.
- R9: Drive-side buffer writes made while a seek is busy do not mark the newly loaded track dirty.
- R10: Seek requests made while a seek is busy are ignored, and the requested cylinder stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe into the shared buffer space |
| host_addr | input | 13 | Host 32-bit word address within the 32 KB buffer |
| host_wdata | input | 32 | Host write data |
| stat_word | output | 32 | Current status word as seen by the host |
| seek_req | input | 1 | Drive-side seek request strobe |
| seek_cyl | input | 8 | Cylinder requested with `seek_req` |
| drv_we | input | 1 | Drive-side sector write into the track buffer |
| ready | output | 1 | Unit online |
| seek_busy | output | 1 | Seek in progress, waiting for the host |
| seek_done | output | 1 | One-cycle pulse when a seek completes |
| seek_err | output | 1 | One-cycle pulse on an out-of-range seek |

## Verification
The hardest cases to reach are the ones that arrive while a seek is still open. These are a drive-side buffer write, a second seek request and a host acknowledge that names the wrong track. Each must leave the handshake state alone, and its effect only shows in later cycles. The bench sweeps every 8-bit cylinder value. Inside each accepted seek it injects these disturbances on a rotating schedule before the correct acknowledge. It also alternates pre-seek buffer writes, so that the dirty bit of the following seek shows whether a write made while busy leaked through.

// File: rtl/tbsk_pkg.sv
package tbsk_pkg;
  localparam int WORD_W     = 32;
  localparam int TRK_W      = 8;
  localparam int ONLINE_BIT = 31;
  localparam int DIRTY_BIT  = 30;
  localparam int REQ_LSB    = 16;
  localparam int LOAD_LSB   = 0;

  typedef struct packed {
    logic             hit;
    logic             online;
    logic [TRK_W-1:0] track;
  } host_stat_t;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic             online,
    input logic             dirty,
    input logic [TRK_W-1:0] req,
    input logic [TRK_W-1:0] loaded
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[ONLINE_BIT]             = online;
    w[DIRTY_BIT]              = dirty;
    w[REQ_LSB +: TRK_W]       = req;
    w[LOAD_LSB +: TRK_W]      = loaded;
    return w;
  endfunction
endpackage

// File: rtl/tbsk_host_decode.sv
module tbsk_host_decode
  import tbsk_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int STAT_ADDR = 127
) (
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output host_stat_t        wr
);
  logic unused_reserved;
  assign unused_reserved = ^host_wdata[ONLINE_BIT-1:LOAD_LSB+TRK_W];

  always_comb begin
    wr.hit    = host_we && (host_addr == ADDR_W'(STAT_ADDR));
    wr.online = host_wdata[ONLINE_BIT];
    wr.track  = host_wdata[LOAD_LSB +: TRK_W];
  end
endmodule

// File: rtl/tbsk_seek_ctl.sv
module tbsk_seek_ctl
  import tbsk_pkg::*;
#(
  parameter int MAX_CYL = 203
) (
  input  logic             clk,
  input  logic             rst,
  input  host_stat_t       wr,
  input  logic             seek_req,
  input  logic [TRK_W-1:0] seek_cyl,
  output logic             online,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [TRK_W-1:0] req_cyl,
  output logic [TRK_W-1:0] loaded,
  output logic             accept,
  output logic             complete
);
  logic considered;
  logic in_range;

  always_comb begin
    considered = seek_req && online && !busy;
    in_range   = (seek_cyl <= TRK_W'(MAX_CYL));
    accept     = considered && in_range;
    complete   = busy && wr.hit && wr.online && (wr.track == req_cyl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      online  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      req_cyl <= '0;
      loaded  <= '0;
    end else begin
      done <= complete;
      err  <= considered && !in_range;
      if (wr.hit) begin
        online <= wr.online;
        loaded <= wr.track;
      end
      if (accept) req_cyl <= seek_cyl;
      if (wr.hit && !wr.online) busy <= 1'b0;
      else if (complete)        busy <= 1'b0;
      else if (accept)          busy <= 1'b1;
    end
  end
endmodule

// File: rtl/tbsk_dirty_track.sv
module tbsk_dirty_track (
  input  logic clk,
  input  logic rst,
  input  logic drv_we,
  input  logic busy,
  input  logic accept,
  input  logic complete,
  output logic dirty
);
  logic written;

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= 1'b0;
      dirty   <= 1'b0;
    end else if (accept) begin
      dirty   <= written || drv_we;
      written <= 1'b0;
    end else begin
      if (complete)        dirty   <= 1'b0;
      if (drv_we && !busy) written <= 1'b1;
    end
  end
endmodule

// File: rtl/tbsk_top.sv
module tbsk_top
  import tbsk_pkg::*;
#(
  parameter int BLOCK_BYTES   = 512,
  parameter int BLOCK_COUNT   = 64,
  parameter int STAT_BYTE_OFS = 508,
  parameter int MAX_CYL       = 203,
  localparam int ADDR_W    = $clog2(BLOCK_COUNT * BLOCK_BYTES / (WORD_W / 8)),
  localparam int STAT_ADDR = STAT_BYTE_OFS / (WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] stat_word,
  input  logic              seek_req,
  input  logic [TRK_W-1:0]  seek_cyl,
  input  logic              drv_we,
  output logic              ready,
  output logic              seek_busy,
  output logic              seek_done,
  output logic              seek_err
);
  host_stat_t       wr;
  logic             online, busy, accept, complete, dirty;
  logic [TRK_W-1:0] req_cyl, loaded;

  tbsk_host_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_dec (
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .wr(wr)
  );

  tbsk_seek_ctl #(.MAX_CYL(MAX_CYL)) u_ctl (
    .clk(clk), .rst(rst), .wr(wr), .seek_req(seek_req), .seek_cyl(seek_cyl),
    .online(online), .busy(busy), .done(seek_done), .err(seek_err),
    .req_cyl(req_cyl), .loaded(loaded), .accept(accept), .complete(complete)
  );

  tbsk_dirty_track u_dirty (
    .clk(clk), .rst(rst), .drv_we(drv_we), .busy(busy),
    .accept(accept), .complete(complete), .dirty(dirty)
  );

  assign ready     = online;
  assign seek_busy = busy;
  assign stat_word = pack_status(online, dirty, req_cyl, loaded);
endmodule

// File: rtl/tbsk_checker.sv
module tbsk_checker #(
  parameter int MAX_CYL = 203
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] stat_word,
  input logic        seek_req,
  input logic [7:0]  seek_cyl,
  input logic        ready,
  input logic        seek_busy,
  input logic        seek_done,
  input logic        seek_err
);
  assert_offline_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !seek_busy);

  assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
    seek_err |-> ($past(seek_req) && ($past(seek_cyl) > 8'(MAX_CYL))));

  assert_err_keeps_req_R4: assert property (@(posedge clk) disable iff (rst)
    seek_err |-> $stable(stat_word[23:16]));

  assert_done_match_R6: assert property (@(posedge clk) disable iff (rst)
    seek_done |-> (stat_word[23:16] == stat_word[7:0]) && !stat_word[30] && !seek_busy);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    seek_done |-> $past(seek_busy));

  assert_req_range_R3: assert property (@(posedge clk) disable iff (rst)
    stat_word[23:16] <= 8'(MAX_CYL));

  assert_busy_holds_req_R10: assert property (@(posedge clk) disable iff (rst)
    (seek_busy && $past(seek_busy)) |-> $stable(stat_word[23:16]));
endmodule

bind tbsk_top tbsk_checker #(.MAX_CYL(MAX_CYL)) u_chk (
  .clk(clk), .rst(rst), .stat_word(stat_word), .seek_req(seek_req),
  .seek_cyl(seek_cyl), .ready(ready), .seek_busy(seek_busy),
  .seek_done(seek_done), .seek_err(seek_err)
);

// File: tb/tbsk_top_test.sv
module tbsk_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [12:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] stat_word;
  logic        seek_req = 1'b0;
  logic [7:0]  seek_cyl = '0;
  logic        drv_we = 1'b0;
  logic        ready, seek_busy, seek_done, seek_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tbsk_top uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .stat_word(stat_word), .seek_req(seek_req),
    .seek_cyl(seek_cyl), .drv_we(drv_we), .ready(ready),
    .seek_busy(seek_busy), .seek_done(seek_done), .seek_err(seek_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [12:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    step();
    host_we = 1'b0;
  endtask

  task automatic do_seek(input logic [7:0] c);
    seek_req = 1'b1; seek_cyl = c;
    step();
    seek_req = 1'b0;
  endtask

  task automatic drv_write();
    drv_we = 1'b1;
    step();
    drv_we = 1'b0;
  endtask

  function automatic logic [31:0] status_of(input logic on, input logic dty,
                                            input logic [7:0] rq, input logic [7:0] ld);
    return {on, dty, 6'd0, rq, 8'd0, ld};
  endfunction

  initial begin
    logic [7:0] last_req;
    logic [7:0] last_load;
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state
    chk("R1 stat_word", stat_word, 32'h0);
    chk("R1 ready", {31'd0, ready}, 32'd0);
    chk("R1 busy", {31'd0, seek_busy}, 32'd0);
    chk("R1 done/err", {30'd0, seek_done, seek_err}, 32'd0);

    // R8: seek while offline ignored
    do_seek(8'd5);
    chk("R8 offline seek busy", {31'd0, seek_busy}, 32'd0);
    chk("R8 offline seek status", stat_word, 32'h0);

    // R2: write to a neighbouring address is ignored
    host_write(13'd126, 32'h8000_0007);
    chk("R2 wrong addr ready", {31'd0, ready}, 32'd0);
    chk("R2 wrong addr status", stat_word, 32'h0);
    host_write(13'd127 + 13'd128, 32'h8000_0000);
    chk("R2 other block ready", {31'd0, ready}, 32'd0);

    // R2: go online at the status word address
    host_write(13'd127, 32'h8000_0000);
    chk("R2 online ready", {31'd0, ready}, 32'd1);
    chk("R2 online status", stat_word, 32'h8000_0000);

    last_req = 8'd0;
    last_load = 8'd0;
    for (int c = 0; c < 256; c++) begin
      logic exp_dirty;
      exp_dirty = c[0];
      if (c[0]) drv_write();
      do_seek(8'(c));
      if (c <= 203) begin
        // R3 / R5
        chk("R3 busy", {31'd0, seek_busy}, 32'd1);
        chk("R3 req field", {24'd0, stat_word[23:16]}, c);
        chk("R5 dirty", {31'd0, stat_word[30]}, {31'd0, exp_dirty});
        chk("R4 no err on valid", {31'd0, seek_err}, 32'd0);
        last_req = 8'(c);
        if (c % 3 == 0) begin
          // R9: write while busy must not leak into next seek's dirty bit
          drv_write();
          chk("R9 busy write keeps busy", {31'd0, seek_busy}, 32'd1);
        end
        if (c % 5 == 2) begin
          // R10: seek during busy ignored
          do_seek(8'((c + 1) % 204));
          chk("R10 req unchanged", {24'd0, stat_word[23:16]}, c);
          chk("R10 still busy", {31'd0, seek_busy}, 32'd1);
        end
        if (c % 4 == 1) begin
          // R7: mismatched acknowledge
          host_write(13'd127, {1'b1, 23'd0, 8'((c + 1) % 256)});
          chk("R7 still busy", {31'd0, seek_busy}, 32'd1);
          chk("R7 status", stat_word, status_of(1'b1, exp_dirty, 8'(c), 8'((c + 1) % 256)));
          chk("R7 no done", {31'd0, seek_done}, 32'd0);
        end
        // R6: correct acknowledge
        host_write(13'd127, {1'b1, 23'd0, 8'(c)});
        chk("R6 busy low", {31'd0, seek_busy}, 32'd0);
        chk("R6 done pulse", {31'd0, seek_done}, 32'd1);
        chk("R6 status", stat_word, status_of(1'b1, 1'b0, 8'(c), 8'(c)));
        last_load = 8'(c);
        step();
        chk("R6 done one cycle", {31'd0, seek_done}, 32'd0);
      end else begin
        // R4: out-of-range seek
        chk("R4 err pulse", {31'd0, seek_err}, 32'd1);
        chk("R4 not busy", {31'd0, seek_busy}, 32'd0);
        chk("R4 req kept", {24'd0, stat_word[23:16]}, {24'd0, last_req});
        chk("R4 status", stat_word, status_of(1'b1, 1'b0, last_req, last_load));
        step();
        chk("R4 err one cycle", {31'd0, seek_err}, 32'd0);
        if (c[0]) begin
          // consume the pending write so the next odd cylinder stays consistent
          do_seek(8'd10);
          chk("R5 dirty after rejected", {31'd0, stat_word[30]}, 32'd1);
          host_write(13'd127, {1'b1, 23'd0, 8'd10});
          last_req = 8'd10;
          last_load = 8'd10;
          step();
        end
      end
    end

    // R8: go offline during a seek
    do_seek(8'd42);
    chk("R8 busy before offline", {31'd0, seek_busy}, 32'd1);
    host_write(13'd127, {1'b0, 23'd0, 8'd10});
    chk("R8 ready low", {31'd0, ready}, 32'd0);
    chk("R8 busy cleared", {31'd0, seek_busy}, 32'd0);
    chk("R8 no done", {31'd0, seek_done}, 32'd0);
    do_seek(8'd7);
    chk("R8 offline seek ignored", {31'd0, seek_busy}, 32'd0);
    chk("R8 req kept offline", {24'd0, stat_word[23:16]}, 32'd42);

    // R2: back online
    host_write(13'd127, {1'b1, 23'd0, 8'd42});
    chk("R2 back online", {31'd0, ready}, 32'd1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule